// File: doc/BRIEF.md
# Envelope Shape Generator

This block produces a 4-bit amplitude envelope that sound channels use to modulate their volume. A free-running prescaler divides the clock by 256. A period counter then divides that tick again by a 16-bit period value, which is assembled from a high and a low byte. Each resulting step moves a 4-bit level counter by one position. A single envelope cycle spans 16 levels.

Four shape bits select the first direction and what happens once a cycle completes. The pattern can fall silent, freeze, restart in the same direction, or reverse to form a triangle. Writing the shape byte, marked by a one-cycle strobe, restarts the envelope at the first level of a fresh cycle and realigns the step timing to that write.

Top module: `env_shaper`

## Requirements
- R1: After reset the level output is 0, and it stays 0 with no step activity until the shape is first written.
- R2: With period P = {periodHi, periodLo} (P ≥ 1), level steps occur exactly 256·P clocks apart. The first step lands 256·P clocks after the clock edge that captured the shape write.
- R3: A period value of 0 gives the same step timing as a period value of 1.
- R4: A shape write (shapeWr high at a clock edge) restarts the envelope. On the next cycle the level is 0 when the attack bit (bit 2) is 1, and 15 when it is 0. The step timing restarts from that edge.
- R5: Inside a cycle, each step moves the level by exactly one in the current direction. This gives 16 distinct levels per cycle: 0 up to 15 when rising, 15 down to 0 when falling.
- R6: When the continue bit (bit 3) is 0, the step after the last level of the first cycle sets the level to 0. The level then never changes until the next shape write, whatever bits 2..0 hold.
- R7: When continue is 1 and hold (bit 0) is 1, the step after the first cycle freezes the output. It keeps the final level when alternate (bit 1) is 0, and it jumps to the opposite extreme when alternate is 1.
- R8: When continue is 1, hold is 0 and alternate is 0, the step after the end of every cycle restarts the level at the cycle's start value (0 when rising, 15 when falling).
- R9: When continue is 1, hold is 0 and alternate is 1, the step after the end of every cycle reverses the direction. The level stays at the extreme for that step and then counts the other way, forming a triangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periodLo | input | 8 | Low byte of the envelope period |
| periodHi | input | 8 | High byte of the envelope period |
| shapeBits | input | 4 | Shape: bit3 continue, bit2 attack, bit1 alternate, bit0 hold |
| shapeWr | input | 1 | One-cycle strobe marking a write of the shape byte |
| envLevel | output | 4 | Current envelope level |

## Verification
The hardest situations to reach are the end-of-cycle transitions, because each one lies 16 steps of 256 or more clocks away from any write. The bench runs all continue/attack/alternate/hold combinations that give distinct behaviour. Each run is long enough to cross one or two cycle ends. The expected levels are queued from a step model, and the monitor samples one clock before and one clock after the first step, which pins the exact step latency. One run uses a high-byte period, so only a 65536-clock wait can show that the upper byte is honoured.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int LVL_W   = 4;
  localparam int PRE_W   = 8;
  localparam int BYTE_W  = 8;
  localparam int PER_W   = 2 * BYTE_W;

  // Strobes issued by the timing control to the level datapath
  typedef struct packed {
    logic restart;  // shape write: reload the cycle
    logic step;     // advance the level by one envelope step
  } envStrobe_t;
endpackage

// File: rtl/env_timer.sv
module env_timer
  import env_pkg::*;
#(
  parameter int PRE_BITS = PRE_W,
  parameter int PER_BITS = PER_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PER_BITS-1:0] period,
  input  logic                shapeWr,
  output envStrobe_t          strb
);
  localparam logic [PER_BITS-1:0] PER_ONE = PER_BITS'(1);

  logic [PRE_BITS-1:0] preCnt;
  logic [PER_BITS-1:0] perCnt;
  logic [PER_BITS-1:0] periodEff;
  logic                preWrap;
  logic                perHit;

  // A zero period is stretched to one
  assign periodEff = (period == '0) ? PER_ONE : period;
  assign preWrap   = &preCnt;
  assign perHit    = perCnt >= (periodEff - PER_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (shapeWr) begin
      preCnt <= '0;
      perCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (preWrap) perCnt <= perHit ? '0 : perCnt + 1'b1;
    end
  end

  assign strb.restart = shapeWr;
  assign strb.step    = preWrap && perHit && !shapeWr;

  // R2: steps are at least a full prescaler turn apart
  p_step_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |=> !strb.step);

  // R4: a restart clears the timing so no step follows at once
  p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> !strb.step);
endmodule

// File: rtl/env_level_dp.sv
module env_level_dp
  import env_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    shapeBits,
  input  envStrobe_t    strb,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] LVL_MAX = {LW{1'b1}};

  logic [3:0] shapeReg;
  logic       goUp;
  logic       frozen;
  logic       atEnd;
  logic       bCont, bAtt, bAlt, bHold;

  assign bCont = shapeReg[3];
  assign bAtt  = shapeBits[2];
  assign bAlt  = shapeReg[1];
  assign bHold = shapeReg[0];
  assign atEnd = goUp ? (level == LVL_MAX) : (level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shapeReg <= '0;
      level    <= '0;
      goUp     <= 1'b0;
      frozen   <= 1'b1;
    end else if (strb.restart) begin
      shapeReg <= shapeBits;
      level    <= bAtt ? '0 : LVL_MAX;
      goUp     <= bAtt;
      frozen   <= 1'b0;
    end else if (strb.step && !frozen) begin
      if (!atEnd) begin
        level <= goUp ? level + 1'b1 : level - 1'b1;
      end else if (!bCont) begin
        level  <= '0;
        frozen <= 1'b1;
      end else if (bHold) begin
        level  <= bAlt ? ~level : level;
        frozen <= 1'b1;
      end else if (bAlt) begin
        goUp <= ~goUp;
      end else begin
        level <= goUp ? '0 : LVL_MAX;
      end
    end
  end

  // R4: restart loads the start level chosen by the attack bit
  p_restart_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> level == ($past(shapeBits[2]) ? '0 : LVL_MAX));

  // R6: a frozen envelope keeps its level until a restart
  p_frozen_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !strb.restart) |=> $stable(level));

  // R5: a mid-cycle step moves the level by exactly one
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.step && !strb.restart && !frozen && !atEnd) |=>
      ((level == $past(level) + 1'b1) || (level == $past(level) - 1'b1)));

  // R1/R5: no level change without a step or restart
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.step && !strb.restart) |=> $stable(level));
endmodule

// File: rtl/env_shaper.sv
module env_shaper
  import env_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] periodLo,
  input  logic [BYTE_W-1:0] periodHi,
  input  logic [3:0]        shapeBits,
  input  logic              shapeWr,
  output logic [LW-1:0]     envLevel
);
  envStrobe_t strb;

  env_timer #(.PRE_BITS(PRE_W), .PER_BITS(PER_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  ({periodHi, periodLo}),
    .shapeWr (shapeWr),
    .strb    (strb)
  );

  env_level_dp #(.LW(LW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .shapeBits (shapeBits),
    .strb      (strb),
    .level     (envLevel)
  );
endmodule

// File: tb/sim_env_shaper.sv
module sim_env_shaper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] periodLo = 8'd1;
  logic [7:0] periodHi = 8'd0;
  logic [3:0] shapeBits = 4'd0;
  logic       shapeWr = 1'b0;
  logic [3:0] envLevel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit monBusy = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int         w;
    logic [3:0] v;
    string      tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;  // 200 MHz

  env_shaper u0 (
    .clk(clk), .rst_n(rst_n), .periodLo(periodLo), .periodHi(periodHi),
    .shapeBits(shapeBits), .shapeWr(shapeWr), .envLevel(envLevel)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: envLevel=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops expected items and compares after their waits
  initial begin
    forever begin
      item_t it;
      wait (expQ.size() > 0);
      monBusy = 1'b1;
      it = expQ.pop_front();
      repeat (it.w) @(negedge clk);
      check(it.tag, envLevel, it.v);
      if (expQ.size() == 0) monBusy = 1'b0;
    end
  end

  // Driver: writes a shape, then queues the expected level after each step
  task automatic runShape(input logic [3:0] shp, input logic [7:0] hi,
                          input logic [7:0] lo, input int nSteps);
    int stepLen;
    logic [3:0] lv;
    bit up, fr;
    string tg;
    stepLen = 256 * ((hi == 0 && lo == 0) ? 1 : int'({hi, lo}));
    @(negedge clk);
    periodHi = hi; periodLo = lo; shapeBits = shp; shapeWr = 1'b1;
    @(negedge clk);
    shapeWr = 1'b0;
    up = shp[2]; fr = 1'b0;
    lv = up ? 4'd0 : 4'd15;
    expQ.push_back('{0, lv, "R4 start level"});
    for (int k = 1; k <= nSteps; k++) begin
      logic [3:0] nx;
      bit atEnd;
      nx = lv;
      atEnd = up ? (lv == 4'd15) : (lv == 4'd0);
      tg = "R5 in-cycle step";
      if (fr) tg = "R6/R7 frozen";
      else if (!atEnd) nx = up ? lv + 4'd1 : lv - 4'd1;
      else if (!shp[3]) begin nx = 4'd0; fr = 1'b1; tg = "R6 single shot end"; end
      else if (shp[0]) begin nx = shp[1] ? ~lv : lv; fr = 1'b1; tg = "R7 hold end"; end
      else if (shp[1]) begin up = !up; tg = "R9 alternate reverse"; end
      else begin nx = up ? 4'd0 : 4'd15; tg = "R8 repeat restart"; end
      if (k == 1) begin
        expQ.push_back('{stepLen - 1, lv, (hi == 0 && lo == 0) ? "R3 no early step" : "R2 no early step"});
        expQ.push_back('{1, nx, (hi == 0 && lo == 0) ? "R3 first step" : "R2 first step"});
      end else begin
        expQ.push_back('{stepLen, nx, tg});
      end
      lv = nx;
    end
    wait (expQ.size() == 0 && !monBusy);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset level", envLevel, 4'd0);
    rst_n = 1'b1;
    repeat (600) @(negedge clk);
    check("R1 idle after reset", envLevel, 4'd0);

    runShape(4'b0000, 8'd0, 8'd1, 18);  // R6 fall once, then 0
    runShape(4'b0100, 8'd0, 8'd0, 19);  // R6 + R3 rise once, drop to 0
    runShape(4'b0110, 8'd0, 8'd1, 18);  // R6 other bits ignored
    runShape(4'b1000, 8'd0, 8'd1, 34);  // R8 repeating fall
    runShape(4'b1100, 8'd0, 8'd1, 20);  // R8 repeating rise
    runShape(4'b1010, 8'd0, 8'd1, 34);  // R9 triangle from top
    runShape(4'b1110, 8'd0, 8'd1, 20);  // R9 triangle from bottom
    runShape(4'b1001, 8'd0, 8'd1, 18);  // R7 hold at final
    runShape(4'b1101, 8'd0, 8'd1, 18);  // R7 hold at final (high)
    runShape(4'b1011, 8'd0, 8'd1, 18);  // R7 alternate hold, jump to 15
    runShape(4'b1111, 8'd0, 8'd1, 18);  // R7 alternate hold, jump to 0
    runShape(4'b1100, 8'd0, 8'd3, 4);   // R2 period 3
    runShape(4'b1100, 8'd0, 8'd1, 5);   // R4 restart mid-pattern
    runShape(4'b0100, 8'd1, 8'd0, 1);   // R2 high byte, period 256

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule